// File: doc/BRIEF.md
# Dual-Mode Five-Requester Bus Arbiter

This block decides which of five requesters owns a shared bus. Requester 0 is the local controller; requesters 1 to 4 are external devices. Ownership is shown as a one-hot grant vector. A new owner is picked only at an access boundary, which the bus-idle input marks. While an access is running, the grant does not move. When nothing is requested at a boundary, the bus parks on requester 0.

Two selection policies are available. Fixed order always prefers the lowest-numbered requester. Rotating order starts its search just after the last owner, so the device that was just served drops to last place. The policy is chosen by a bit in a 32-bit control register. That register changes only when the write carries the key byte 0xA5 in its top eight bits. The register also holds an initialization-done flag. A strap input says whether this unit is the host. When it is not, no external device is ever granted.

Top module: `bus_grant_arbiter`

## Requirements
- R1: After reset the grant is 5'b00001 (requester 0) and the control readback is 0.
- R2: The grant vector has exactly one bit set in every cycle.
- R3: In fixed mode (control bit 1 = 0), an arbitration grants the requesting device with the lowest index. A higher index is starved while a lower one keeps requesting.
- R4: In rotating mode (control bit 1 = 1), the search starts at the index after the last device that won an arbitration and wraps from 4 to 0. Right after reset the search starts at 0.
- R5: Arbitration happens only at a rising clock edge where bus_idle_i is 1. On any other edge the grant is held.
- R6: An arbitration with no request pending grants requester 0.
- R7: While host_mode_i is 0, the grant after each edge is 5'b00001, whatever the requests and the mode bit. The rotation start is not updated in that cycle.
- R8: A register write changes the stored bits only when write data bits 31:24 equal 0xA5. A write with any other key leaves the readback unchanged.
- R9: The readback bit 1 is the mode and bit 0 is the init-done flag. Bits 31:2 read as 0, so the key is never returned.
- R10: Every arbitration that has a winner records that winner, in fixed mode as well as rotating mode. A later switch to rotating mode continues from the recorded winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | Strap: 1 = this unit is the host |
| req_i | input | 5 | Request vector; bit n belongs to requester n |
| bus_idle_i | input | 1 | 1 = access boundary; arbitration is allowed at this edge |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Write data; bits 31:24 carry the key |
| reg_rdata_o | output | 32 | Control register readback |
| gnt_o | output | 5 | One-hot grant vector |

## Verification
On every cycle the assertions check the following: the grant stays one-hot, it holds steady while the bus is busy, it parks on requester 0 when nothing is requested or the unit is not the host, and any granted device was actually requesting. They also check that a wrongly keyed write leaves the readback unchanged and that a keyed write stores its low bits. The ordering policies themselves can only be shown by the bench's scenarios. These cover starvation under fixed order, a full fair cycle under rotation, the rotation start carried across a mode switch, and a return from non-host mode.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned ARB_REQS  = 5;
    localparam int unsigned CTRL_DW   = 32;
    localparam logic [7:0]  UNLOCK    = 8'hA5;
    localparam int unsigned MODE_POS  = 1;
    localparam int unsigned INIT_POS  = 0;

    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_mode_e;

    typedef struct packed {
        arb_mode_e mode;
        logic      init_done;
    } arb_ctrl_t;

endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
    import arb_pkg::*;
#(
    parameter int unsigned DW = CTRL_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output arb_ctrl_t     ctrl_o
);

    localparam int unsigned KEY_LSB = DW - 8;

    arb_ctrl_t ctrl_d, ctrl_q;
    logic      key_ok;
    logic      unused_wdata;

    assign key_ok       = (wdata_i[DW-1:KEY_LSB] == UNLOCK);
    assign unused_wdata = ^wdata_i[KEY_LSB-1:MODE_POS+1];

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i && key_ok) begin
            ctrl_d.mode      = arb_mode_e'(wdata_i[MODE_POS]);
            ctrl_d.init_done = wdata_i[INIT_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{mode: ARB_FIXED, init_done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[MODE_POS] = ctrl_q.mode;
        rdata_o[INIT_POS] = ctrl_q.init_done;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int unsigned N  = 5,
    parameter int unsigned PW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] start_i,
    input  logic          rotate_i,
    output logic          any_o,
    output logic [PW-1:0] win_o
);

    logic [PW-1:0] base;

    assign base = rotate_i ? start_i : '0;

    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int k = 0; k < int'(N); k++) begin
            int cand;
            cand = int'(base) + k;
            if (cand >= int'(N)) cand = cand - int'(N);
            if (!any_o && req_i[cand]) begin
                any_o = 1'b1;
                win_o = PW'(cand);
            end
        end
    end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned NUM_REQ = ARB_REQS,
    parameter int unsigned DW      = CTRL_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_mode_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               bus_idle_i,
    input  logic               reg_we_i,
    input  logic [DW-1:0]      reg_wdata_i,
    output logic [DW-1:0]      reg_rdata_o,
    output logic [NUM_REQ-1:0] gnt_o
);

    localparam int unsigned          PW   = $clog2(NUM_REQ);
    localparam logic [PW-1:0]        LAST = PW'(NUM_REQ - 1);
    localparam logic [NUM_REQ-1:0]   PARK = NUM_REQ'(1);

    typedef struct packed {
        logic [NUM_REQ-1:0] gnt;
        logic [PW-1:0]      start;
    } arb_state_t;

    arb_state_t st_d, st_q;
    arb_ctrl_t  ctrl;
    logic       pick_any;
    logic [PW-1:0] pick_win;

    arb_ctrl_reg #(.DW(DW)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl)
    );

    arb_prio_pick #(.N(NUM_REQ), .PW(PW)) pick_i (
        .req_i    (req_i),
        .start_i  (st_q.start),
        .rotate_i (ctrl.mode == ARB_ROTATE),
        .any_o    (pick_any),
        .win_o    (pick_win)
    );

    always_comb begin
        st_d = st_q;
        if (!host_mode_i) begin
            st_d.gnt = PARK;
        end else if (bus_idle_i) begin
            if (pick_any) begin
                st_d.gnt           = '0;
                st_d.gnt[pick_win] = 1'b1;
                st_d.start         = (pick_win == LAST) ? '0 : pick_win + 1'b1;
            end else begin
                st_d.gnt = PARK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{gnt: PARK, start: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int unsigned NUM_REQ = 5,
    parameter int unsigned DW      = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_mode_i,
    input logic [NUM_REQ-1:0] req_i,
    input logic               bus_idle_i,
    input logic               reg_we_i,
    input logic [DW-1:0]      reg_wdata_i,
    input logic [DW-1:0]      reg_rdata_o,
    input logic [NUM_REQ-1:0] gnt_o
);

    localparam logic [NUM_REQ-1:0] PARK = NUM_REQ'(1);

    // R2
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_o) == 1);

    // R5
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && !bus_idle_i) |=> $stable(gnt_o));

    // R6
    park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && bus_idle_i && req_i == '0) |=> gnt_o == PARK);

    // R3
    winner_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && bus_idle_i && req_i != '0) |=> (gnt_o & $past(req_i)) != '0);

    // R7
    nonhost_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode_i |=> gnt_o == PARK);

    // R8
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_wdata_i[DW-1:DW-8] != 8'hA5) |=> $stable(reg_rdata_o));

    // R8
    good_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_wdata_i[DW-1:DW-8] == 8'hA5)
        |=> reg_rdata_o[1:0] == $past(reg_wdata_i[1:0]));

endmodule

bind bus_grant_arbiter arb_checker #(.NUM_REQ(NUM_REQ), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_mode_i (host_mode_i),
    .req_i       (req_i),
    .bus_idle_i  (bus_idle_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .gnt_o       (gnt_o)
);

// File: tb/bus_grant_arbiter_tb_top.sv
module bus_grant_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode_i = 1'b1;
    logic [4:0]  req_i = '0;
    logic        bus_idle_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [4:0]  gnt_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          cg;
        logic [4:0]  gnt;
        bit          cr;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_grant_arbiter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_mode_i (host_mode_i),
        .req_i       (req_i),
        .bus_idle_i  (bus_idle_i),
        .reg_we_i    (reg_we_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .gnt_o       (gnt_o)
    );

    task automatic step(input logic h, input logic [4:0] r, input logic idle,
                        input logic we, input logic [31:0] wd,
                        input bit cg, input logic [4:0] eg,
                        input bit cr, input logic [31:0] er, input string tag);
        exp_t e;
        @(negedge clk);
        host_mode_i = h;
        req_i       = r;
        bus_idle_i  = idle;
        reg_we_i    = we;
        reg_wdata_i = wd;
        e.cg = cg; e.gnt = eg; e.cr = cr; e.rd = er; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic arb(input logic [4:0] r, input logic [4:0] eg, input string tag);
        step(1'b1, r, 1'b1, 1'b0, 32'h0, 1'b1, eg, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [31:0] wd, input logic [31:0] er, input string tag);
        step(1'b1, 5'b0, 1'b0, 1'b1, wd, 1'b0, 5'b0, 1'b1, er, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.cg) begin
                    checks++;
                    if (gnt_o !== e.gnt) begin
                        failures++;
                        $display("FAIL %s gnt actual=%b expected=%b", e.tag, gnt_o, e.gnt);
                    end
                    // R2: one-hot grant on every checked cycle
                    checks++;
                    if ($countones(gnt_o) != 1) begin
                        failures++;
                        $display("FAIL R2 onehot actual=%b expected=one bit", gnt_o);
                    end
                end
                if (e.cr) begin
                    checks++;
                    if (reg_rdata_o !== e.rd) begin
                        failures++;
                        $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata_o, e.rd);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 3000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(1'b1, 5'b0, 1'b0, 1'b0, 32'h0, 1'b1, 5'b00001, 1'b1, 32'h0, "R1");
        // R3 fixed order, device 4 starved
        arb(5'b11110, 5'b00010, "R3");
        arb(5'b11110, 5'b00010, "R3");
        arb(5'b11110, 5'b00010, "R3");
        // R5 busy bus holds grant
        step(1'b1, 5'b10000, 1'b0, 1'b0, 32'h0, 1'b1, 5'b00010, 1'b0, 32'h0, "R5");
        step(1'b1, 5'b10000, 1'b0, 1'b0, 32'h0, 1'b1, 5'b00010, 1'b0, 32'h0, "R5");
        // R6 idle with no request parks
        arb(5'b00000, 5'b00001, "R6");
        // R8 wrong key ignored, right key accepted
        wr(32'h5A000003, 32'h0, "R8");
        wr(32'h00000003, 32'h0, "R8");
        wr(32'hA5000003, 32'h00000003, "R8");
        // R9 reserved bits read zero, key not returned
        wr(32'hA5FFFFFE, 32'h00000002, "R9");
        // R4 rotation: last winner 1 -> start at 2
        arb(5'b11111, 5'b00100, "R4");
        arb(5'b11111, 5'b01000, "R4");
        arb(5'b11111, 5'b10000, "R4");
        arb(5'b11111, 5'b00001, "R4");
        arb(5'b11111, 5'b00010, "R4");
        arb(5'b00011, 5'b00001, "R4");
        arb(5'b00011, 5'b00010, "R4");
        // R10 winner recorded in fixed mode too
        wr(32'hA5000001, 32'h00000001, "R10");
        arb(5'b01000, 5'b01000, "R10");
        wr(32'hA5000003, 32'h00000003, "R10");
        arb(5'b10001, 5'b10000, "R10");
        // R7 non-host: only requester 0, mode ignored
        step(1'b0, 5'b11110, 1'b1, 1'b0, 32'h0, 1'b1, 5'b00001, 1'b0, 32'h0, "R7");
        step(1'b0, 5'b11111, 1'b0, 1'b0, 32'h0, 1'b1, 5'b00001, 1'b0, 32'h0, "R7");
        step(1'b0, 5'b00100, 1'b1, 1'b0, 32'h0, 1'b1, 5'b00001, 1'b1, 32'h00000003, "R7");
        // back to host: start was 0 after winner 4
        arb(5'b00110, 5'b00010, "R7");
        step(1'b1, 5'b0, 1'b0, 1'b0, 32'h0, 1'b0, 5'b0, 1'b0, 32'h0, "idle");
        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule